// File: doc/BRIEF.md
# Late-Write Pipelined SRAM with Per-Byte Bypass

This block is a single-clock synchronous memory that uses a late-write protocol. A command (select, write flag, byte enables and address) is sampled on a rising clock edge. For a write, the data belonging to that command is sampled on the next rising edge and placed in a one-entry pending-write buffer. The buffer is moved into the storage array only when the data of the following write arrives. Until then the array keeps its old contents for that word.

A read returns its word from an output register, so the word appears after the clock edge that follows the read command. If the read address equals the address held in the pending-write buffer, each byte that the pending write enabled comes from the buffer. The other bytes come from the array. The output is presented on a bidirectional bus that is modelled as separate input, output and output-enable ports.

An active-low output enable and a sleep input both force the bus enable low. While sleep is high, commands are ignored and the array keeps its contents.

Top module: `latewrite_sram`

## Requirements
- R1: A read command sampled at rising edge N loads `dq_out` at edge N+1. `dq_oe` is high from edge N+1 to edge N+2 when `oe_n` is low and `sleep` is low. A command sampled with `cs` high and `we` low is a read.
- R2: For a write command sampled at edge N (`cs` and `we` high), the write data is the value of `dq_in` at edge N+1. Nothing on `dq_in` is used at any other edge.
- R3: The pending write is placed into the array only at the edge that captures the data of the next write. A read of a word whose pending write has been replaced by a write to another address returns the data that was placed into the array.
- R4: A read whose address equals the pending write address takes byte b from the pending write when that write enabled byte b. It takes byte b from the array otherwise.
- R5: The word has four byte lanes of 9 bits each. Lane b occupies `dq` bits [9b+8:9b] and is enabled by `be[b]`, where 1 means write. A write with `be` = 0 changes no byte, both in the array and as seen through the bypass.
- R6: A command sampled with `cs` low performs no operation: it stores no data and drives no output.
- R7: `oe_n` high forces `dq_oe` low at once. The registered read data stays unchanged and is driven again when `oe_n` goes low.
- R8: While `sleep` is high, `dq_oe` is low and every command and write data is ignored. The array contents are kept.
- R9: Back-to-back reads of the same address, with no write data captured between them, keep `dq_out` at the same value with no intermediate change.
- R10: While `rst_n` is low, and after its release, `dq_oe` is low and `dq_out` is 0 until a read completes. No write is pending after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of control state |
| sleep | input | 1 | Low-power request; ignores commands and disables outputs |
| cs | input | 1 | Command select, active high |
| we | input | 1 | Write flag of the command (1 write, 0 read) |
| be | input | NB | Byte-lane write enables, lane b on bits [9b+8:9b] |
| addr | input | AW | Word address of the command |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| dq_in | input | NB*BW | Bus value seen by the memory (write data) |
| dq_out | output | NB*BW | Registered read data |
| dq_oe | output | 1 | Drive enable for the bus |

## Verification
The main function is tried with a command stream that mixes write-after-write, a read right after a write to the same address (full bypass), a partial-byte write followed by reads (mixed bypass and array lanes), and a write with no lanes enabled followed by a read of the displaced word. Together these show whether data comes from the pending buffer, from the array, or from a stale buffer. Directed passes then hold `oe_n` high, raise `sleep` around write and read commands, and issue back-to-back reads of one address. These passes show whether the output gating is combinational, whether sleep and deselect really leave the storage untouched, and whether repeated reads stay glitch-free.

// File: rtl/lw_pkg.sv
package lw_pkg;
  // Operation held in the command stage
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;
endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
  import lw_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          cs,
  input  logic          we,
  input  logic [NB-1:0] be,
  input  logic [AW-1:0] addr,
  output lw_op_e        op,
  output logic [AW-1:0] op_addr,
  output logic [NB-1:0] op_be
);
  logic accept;
  assign accept = cs && !sleep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op      <= OP_NONE;
      op_addr <= '0;
      op_be   <= '0;
    end else begin
      if (accept) begin
        op      <= we ? OP_WRITE : OP_READ;
        op_addr <= addr;
        op_be   <= be;
      end else begin
        op <= OP_NONE;
      end
    end
  end
endmodule

// File: rtl/lw_write_buffer.sv
module lw_write_buffer
  import lw_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 9,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  lw_op_e        op,
  input  logic [AW-1:0] op_addr,
  input  logic [NB-1:0] op_be,
  input  logic [DW-1:0] din,
  output logic          hold_valid,
  output logic [AW-1:0] hold_addr,
  output logic [NB-1:0] hold_be,
  output logic [DW-1:0] hold_data,
  output logic          commit
);
  logic capture;
  assign capture = (op == OP_WRITE) && !sleep;
  // The held write moves to the array when the next write's data lands
  assign commit  = capture && hold_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_addr  <= '0;
      hold_be    <= '0;
      hold_data  <= '0;
    end else if (capture) begin
      hold_valid <= 1'b1;
      hold_addr  <= op_addr;
      hold_be    <= op_be;
      hold_data  <= din;
    end
  end
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int DEPTH = 256,
  parameter int NB    = 4,
  parameter int BW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = NB * BW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [NB-1:0] wr_be,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) begin
        lane_mem[wr_addr] <= wr_data[b*BW +: BW];
      end
    end

    assign rd_data[b*BW +: BW] = lane_mem[rd_addr];
  end
endmodule

// File: rtl/lw_read_path.sv
module lw_read_path
  import lw_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 9,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lw_op_e        op,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] arr_data,
  input  logic          hold_valid,
  input  logic [AW-1:0] hold_addr,
  input  logic [NB-1:0] hold_be,
  input  logic [DW-1:0] hold_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic          hit;
  logic [DW-1:0] merged;

  assign hit = hold_valid && (hold_addr == op_addr);

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[b*BW +: BW] = (hit && hold_be[b]) ? hold_data[b*BW +: BW]
                                                    : arr_data[b*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= (op == OP_READ);
      if (op == OP_READ) begin
        rd_data <= merged;
      end
    end
  end
endmodule

// File: rtl/latewrite_sram.sv
module latewrite_sram
  import lw_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int NB    = 4,
  parameter int BW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          cs,
  input  logic          we,
  input  logic [NB-1:0] be,
  input  logic [AW-1:0] addr,
  input  logic          oe_n,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  lw_op_e        op;
  logic [AW-1:0] op_addr;
  logic [NB-1:0] op_be;
  logic          hold_valid;
  logic [AW-1:0] hold_addr;
  logic [NB-1:0] hold_be;
  logic [DW-1:0] hold_data;
  logic          commit;
  logic [DW-1:0] arr_data;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  lw_cmd_stage #(.AW(AW), .NB(NB)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs(cs), .we(we),
    .be(be), .addr(addr), .op(op), .op_addr(op_addr), .op_be(op_be)
  );

  lw_write_buffer #(.AW(AW), .NB(NB), .BW(BW)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .op(op), .op_addr(op_addr),
    .op_be(op_be), .din(dq_in), .hold_valid(hold_valid),
    .hold_addr(hold_addr), .hold_be(hold_be), .hold_data(hold_data),
    .commit(commit)
  );

  lw_array #(.DEPTH(DEPTH), .NB(NB), .BW(BW)) u_array (
    .clk(clk), .wr_en(commit), .wr_addr(hold_addr), .wr_be(hold_be),
    .wr_data(hold_data), .rd_addr(op_addr), .rd_data(arr_data)
  );

  lw_read_path #(.AW(AW), .NB(NB), .BW(BW)) u_rd (
    .clk(clk), .rst_n(rst_n), .op(op), .op_addr(op_addr),
    .arr_data(arr_data), .hold_valid(hold_valid), .hold_addr(hold_addr),
    .hold_be(hold_be), .hold_data(hold_data), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  assign dq_out = rd_data;
  assign dq_oe  = rd_valid && !oe_n && !sleep;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 9,
  localparam int DW = NB * BW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          cs,
  input logic          we,
  input logic [NB-1:0] be,
  input logic [AW-1:0] addr,
  input logic          oe_n,
  input logic [DW-1:0] dq_in,
  input logic          dq_oe,
  input logic [AW-1:0] hold_addr,
  input logic [NB-1:0] hold_be,
  input logic [DW-1:0] hold_data
);
  // R8: sleeping memory never drives the bus
  assert_sleep_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);

  // R7: output enable high keeps the bus released
  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  // R1 / R6: a driven bus always traces back to an accepted read two edges earlier
  assert_drive_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(cs && !we && !sleep && rst_n, 2));

  // R2: write data is the bus value one edge after the command
  assert_data_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs && we && !sleep && rst_n, 2) && $past(!sleep && rst_n))
      |-> (hold_data == $past(dq_in) && hold_addr == $past(addr, 2)));

  // R5: lane enables follow the command into the pending buffer
  assert_lane_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs && we && !sleep && rst_n, 2) && $past(!sleep && rst_n))
      |-> (hold_be == $past(be, 2)));
endmodule

bind latewrite_sram lw_sram_chk #(.AW(AW), .NB(NB), .BW(BW)) u_lw_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs(cs), .we(we), .be(be),
  .addr(addr), .oe_n(oe_n), .dq_in(dq_in), .dq_oe(dq_oe),
  .hold_addr(hold_addr), .hold_be(hold_be), .hold_data(hold_data)
);

// File: tb/test_latewrite_sram.sv
module test_latewrite_sram;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int NB    = 4;
  localparam int BW    = 9;
  localparam int AW    = 8;
  localparam int DW    = 36;
  localparam int EW    = 2 + NB + AW + DW;
  localparam int NV    = 14;
  localparam logic [DW-1:0] JUNK = 36'hF0F0F0F0F;

  function automatic logic [DW-1:0] mk(logic [8:0] l3, logic [8:0] l2,
                                       logic [8:0] l1, logic [8:0] l0);
    return {l3, l2, l1, l0};
  endfunction

  // entry = {cs, we, be, addr, data}; data is write data or expected read data
  localparam logic [EW-1:0] TBL [NV] = '{
    {1'b1, 1'b1, 4'b1111, 8'h10, mk(9'h001, 9'h002, 9'h003, 9'h004)},
    {1'b1, 1'b1, 4'b1111, 8'h20, mk(9'h005, 9'h006, 9'h007, 9'h008)},
    {1'b1, 1'b0, 4'b0000, 8'h10, mk(9'h001, 9'h002, 9'h003, 9'h004)},
    {1'b1, 1'b0, 4'b0000, 8'h20, mk(9'h005, 9'h006, 9'h007, 9'h008)},
    {1'b1, 1'b1, 4'b0001, 8'h20, mk(9'h0F0, 9'h0F0, 9'h0F0, 9'h111)},
    {1'b1, 1'b0, 4'b0000, 8'h20, mk(9'h005, 9'h006, 9'h007, 9'h111)},
    {1'b1, 1'b0, 4'b0000, 8'h20, mk(9'h005, 9'h006, 9'h007, 9'h111)},
    {1'b1, 1'b1, 4'b0000, 8'h30, mk(9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF)},
    {1'b1, 1'b0, 4'b0000, 8'h20, mk(9'h005, 9'h006, 9'h007, 9'h111)},
    {1'b1, 1'b1, 4'b1010, 8'h10, mk(9'h01A, 9'h01B, 9'h01C, 9'h01D)},
    {1'b1, 1'b0, 4'b0000, 8'h10, mk(9'h01A, 9'h002, 9'h01C, 9'h004)},
    {1'b0, 1'b1, 4'b1111, 8'h10, mk(9'h155, 9'h155, 9'h155, 9'h155)},
    {1'b1, 1'b0, 4'b0000, 8'h10, mk(9'h01A, 9'h002, 9'h01C, 9'h004)},
    {1'b1, 1'b0, 4'b0000, 8'h20, mk(9'h005, 9'h006, 9'h007, 9'h111)}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep = 1'b0;
  logic          cs = 1'b0;
  logic          we = 1'b0;
  logic [NB-1:0] be = '0;
  logic [AW-1:0] addr = '0;
  logic          oe_n = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  latewrite_sram #(.DEPTH(DEPTH), .NB(NB), .BW(BW)) i_latewrite_sram (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs(cs), .we(we), .be(be),
    .addr(addr), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic c, logic w, logic [NB-1:0] b, logic [AW-1:0] a,
                     logic [DW-1:0] d);
    @(negedge clk);
    cs = c; we = w; be = b; addr = a; dq_in = d;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] first_val;
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 dq_oe in reset", dq_oe, 0);
    check("R10 dq_out in reset", dq_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 dq_oe after reset", dq_oe, 0);
    check("R10 dq_out after reset", dq_out, 0);

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        logic [EW-1:0] e;
        e = TBL[i-2];
        if (e[EW-1] && !e[EW-2]) begin
          check($sformatf("R1/R3/R4/R5 table oe step %0d", i - 2), dq_oe, 1);
          check($sformatf("R1/R2/R3/R4/R5 table data step %0d", i - 2),
                dq_out, e[DW-1:0]);
        end else begin
          check($sformatf("R1/R6 table idle step %0d", i - 2), dq_oe, 0);
        end
      end
      if (i < NV) begin
        logic [EW-1:0] c;
        c = TBL[i];
        cs = c[EW-1]; we = c[EW-2]; be = c[EW-3 -: NB];
        addr = c[DW +: AW];
      end else begin
        cs = 1'b0; we = 1'b0; be = '0; addr = '0;
      end
      dq_in = JUNK;
      if (i >= 1 && i <= NV) begin
        logic [EW-1:0] p;
        p = TBL[i-1];
        if (p[EW-1] && p[EW-2]) dq_in = p[DW-1:0];
      end
    end

    // R7: output enable gating
    oe_n = 1'b1;
    cyc(1'b1, 1'b0, '0, 8'h10, JUNK);
    cyc(1'b0, 1'b0, '0, 8'h00, JUNK);
    @(negedge clk);
    check("R7 dq_oe with oe_n high", dq_oe, 0);
    oe_n = 1'b0;
    #1;
    check("R7 dq_oe after oe_n low", dq_oe, 1);
    check("R7 data kept", dq_out, mk(9'h01A, 9'h002, 9'h01C, 9'h004));
    oe_n = 1'b1;
    #1;
    check("R7 dq_oe released", dq_oe, 0);
    oe_n = 1'b0;

    // R8: sleep ignores commands and data, keeps contents
    cyc(1'b1, 1'b0, '0, 8'h20, JUNK);
    @(negedge clk);
    sleep = 1'b1;
    cs = 1'b1; we = 1'b1; be = 4'b1111; addr = 8'h10; dq_in = JUNK;
    #1;
    check("R8 read result hidden by sleep", dq_oe, 0);
    cyc(1'b1, 1'b1, 4'b1111, 8'h20, JUNK);
    cyc(1'b1, 1'b0, '0, 8'h10, JUNK);
    @(negedge clk);
    check("R8 no drive during sleep", dq_oe, 0);
    sleep = 1'b0;
    cs = 1'b1; we = 1'b0; be = '0; addr = 8'h10;
    cyc(1'b1, 1'b0, '0, 8'h20, JUNK);
    cyc(1'b0, 1'b0, '0, 8'h00, JUNK);
    check("R8 word 10 preserved", dq_out, mk(9'h01A, 9'h002, 9'h01C, 9'h004));
    @(negedge clk);
    check("R8 word 20 preserved", dq_out, mk(9'h005, 9'h006, 9'h007, 9'h111));

    // R9: back-to-back reads of one address hold steady
    cyc(1'b1, 1'b0, '0, 8'h20, JUNK);
    cyc(1'b1, 1'b0, '0, 8'h20, JUNK);
    cyc(1'b1, 1'b0, '0, 8'h20, JUNK);
    first_val = dq_out;
    check("R9 first repeated read", first_val,
          mk(9'h005, 9'h006, 9'h007, 9'h111));
    @(posedge clk);
    #1;
    check("R9 value stable across edge", dq_out, first_val);
    check("R9 drive stays on", dq_oe, 1);
    cs = 1'b0;
    @(posedge clk);
    #1;
    check("R9 value stable on last read", dq_out, first_val);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule